// File: doc/BRIEF.md
# Passive LCD refresh timing and fetch controller

This block paces the refresh of a passive LCD panel. From the panel geometry and the colour mode it derives a per-line transfer count and a per-frame line count. While video is running it requests framebuffer words one after another, walking a word address upward from a programmed start address, and it stops advancing at a programmed end address. It marks the completion of every line and every frame with single-cycle pulses and drives a frame polarity signal that alternates so that the panel sees no DC bias.

Software stops the display in one of two ways. Dropping the enable or the display-on control stops fetching and blanks the pixel nibble at once. Raising the freeze control lets the frame in progress finish, then halts and reports this on a done flag. A halted block always restarts at the top of the frame, with the address reloaded. An arbiter outside the block grants the fetch requests, and each granted cycle counts as one transfer. The 4-bit pixel nibble on its way to the panel can be inverted.

Top module: `lcd_refresh_ctrl`

## Requirements
- R1: With `color8_i`=1 and `split_i`=0, `hcnt_o` equals (width/8)*3-1, using integer division.
- R2: In every other combination of `color8_i` and `split_i`, `hcnt_o` equals width/4-1.
- R3: `lcnt_o` equals height-1 when `split_i`=0 and height/2-1 when `split_i`=1.
- R4: While running, `fetch_addr_o` starts each frame at `start_addr_i` and goes up by one for each granted transfer (`fetch_req_o` and `fetch_gnt_i` both high). It holds once it equals `end_addr_i` and reloads `start_addr_i` after the last transfer of the frame.
- R5: `line_pulse_o` is high for the one cycle after each (hcnt+1)-th transfer of a line. `frame_pulse_o` is high in the same cycle as the line pulse that ends line lcnt+1.
- R6: `df_o` resets to 0. With `df_mode_i`=0 it toggles with every frame pulse, and with `df_mode_i`=1 it toggles with every line pulse.
- R7: If `freeze_i` is high at the last transfer of a frame, `frame_done_o` goes to 1 in the cycle of that frame pulse and `fetch_req_o` drops to 0. Before that point a high `freeze_i` changes nothing.
- R8: `fetch_req_o` is high exactly when `video_en_i` and `disp_on_i` are both 1 and the block is not frozen. While it is low, `pix_data_o` is 0. A cycle with `video_en_i`=0 clears `frame_done_o`.
- R9: After any stop, refresh resumes at line 0, transfer 0, with `fetch_addr_o` equal to `start_addr_i` on the first request.
- R10: While running, `pix_data_o` equals `pix_data_i` when `invert_i`=0 and its bitwise complement when `invert_i`=1.
- R11: After reset, `fetch_req_o`, `line_pulse_o`, `frame_pulse_o`, `df_o` and `frame_done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_addr_i | input | AW | First framebuffer word address |
| end_addr_i | input | AW | Word address at which fetching stops advancing |
| width_i | input | W_W | Panel width in pixels |
| height_i | input | H_W | Panel height in lines |
| color8_i | input | 1 | 1 selects 8-bit colour mode |
| split_i | input | 1 | 1 selects split (dual) panel |
| video_en_i | input | 1 | Video logic enable |
| disp_on_i | input | 1 | Display on |
| freeze_i | input | 1 | Halt at the end of the current frame |
| invert_i | input | 1 | Invert the pixel nibble |
| df_mode_i | input | 1 | 0: DF toggles per frame, 1: per line |
| fetch_gnt_i | input | 1 | Fetch grant from the memory arbiter |
| pix_data_i | input | 4 | Pixel nibble from the dither path |
| hcnt_o | output | W_W | Derived transfers-per-line minus one |
| lcnt_o | output | H_W | Derived lines-per-frame minus one |
| fetch_req_o | output | 1 | Fetch request |
| fetch_addr_o | output | AW | Fetch word address |
| line_pulse_o | output | 1 | One-cycle end-of-line pulse |
| frame_pulse_o | output | 1 | One-cycle end-of-frame pulse |
| df_o | output | 1 | Frame polarity signal |
| frame_done_o | output | 1 | Halted after a freeze |
| pix_data_o | output | 4 | Pixel nibble to the panel |

## Verification
If the transfer or line counter holds a wrong value, a line or frame pulse lands in the wrong cycle. It shows on the first pulse after the fault, at the latest one line or one frame later. A wrong address register shows on `fetch_addr_o` at the next granted transfer. A stale frozen flag keeps `fetch_req_o` low, or lets it stay high past the frame boundary, in the very next cycle. The bench therefore compares every output in every cycle against a transfer-count model under random grant gaps, so any such fault is caught within one frame.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  // events produced by the scan counters, qualified by a granted transfer
  typedef struct packed {
    logic line_end;
    logic frame_end;
  } scan_evt_t;

  typedef enum logic [1:0] {
    VS_STOP   = 2'd0,
    VS_RUN    = 2'd1,
    VS_FROZEN = 2'd2
  } vid_state_e;
endpackage

// File: rtl/lcd_geom_decode.sv
module lcd_geom_decode #(
  parameter int W_W = 12,
  parameter int H_W = 11
) (
  input  logic [W_W-1:0] width_i,
  input  logic [H_W-1:0] height_i,
  input  logic           color8_i,
  input  logic           split_i,
  output logic [W_W-1:0] hcnt_o,
  output logic [H_W-1:0] lcnt_o
);
  localparam int EXT_W = W_W + 2;

  logic [EXT_W-1:0] rgb_words;
  logic [W_W-1:0]   nib_words;
  logic [H_W-1:0]   rows;

  // 8-bit colour on a single panel carries three subpixels per pixel
  assign rgb_words = EXT_W'(width_i >> 3) * EXT_W'(3);
  assign nib_words = width_i >> 2;
  assign rows      = split_i ? (height_i >> 1) : height_i;

  always_comb begin
    if (color8_i && !split_i) hcnt_o = rgb_words[W_W-1:0] - W_W'(1);
    else                      hcnt_o = nib_words - W_W'(1);
    lcnt_o = rows - H_W'(1);
  end
endmodule

// File: rtl/lcd_scan_ctr.sv
module lcd_scan_ctr
  import lcd_pkg::*;
#(
  parameter int W_W = 12,
  parameter int H_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           xfer_i,
  input  logic [W_W-1:0] hcnt_i,
  input  logic [H_W-1:0] lcnt_i,
  output scan_evt_t      evt_o,
  output logic           line_pulse_o,
  output logic           frame_pulse_o
);
  logic [W_W-1:0] x_q;
  logic [H_W-1:0] y_q;
  logic           x_last, y_last;

  assign x_last          = (x_q == hcnt_i);
  assign y_last          = (y_q == lcnt_i);
  assign evt_o.line_end  = xfer_i && x_last;
  assign evt_o.frame_end = xfer_i && x_last && y_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (!run_i) begin
      x_q <= '0;
      y_q <= '0;
    end else if (xfer_i) begin
      if (x_last) begin
        x_q <= '0;
        y_q <= y_last ? '0 : y_q + H_W'(1);
      end else begin
        x_q <= x_q + W_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_pulse_o  <= 1'b0;
      frame_pulse_o <= 1'b0;
    end else begin
      line_pulse_o  <= evt_o.line_end;
      frame_pulse_o <= evt_o.frame_end;
    end
  end
endmodule

// File: rtl/lcd_fetch_addr.sv
module lcd_fetch_addr #(
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          xfer_i,
  input  logic          frame_end_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW-1:0] end_addr_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    addr_o <= '0;
    else if (!run_i || frame_end_i) addr_o <= start_addr_i;
    else if (xfer_i && addr_o != end_addr_i) addr_o <= addr_o + AW'(1);
  end
endmodule

// File: rtl/lcd_run_ctrl.sv
module lcd_run_ctrl
  import lcd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      video_en_i,
  input  logic      disp_on_i,
  input  logic      freeze_i,
  input  logic      df_mode_i,
  input  scan_evt_t evt_i,
  output logic      run_o,
  output logic      frozen_o,
  output logic      df_o
);
  vid_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      VS_STOP:   if (video_en_i && disp_on_i) st_d = VS_RUN;
      VS_RUN:    if (!(video_en_i && disp_on_i)) st_d = VS_STOP;
                 else if (evt_i.frame_end && freeze_i) st_d = VS_FROZEN;
      VS_FROZEN: if (!video_en_i) st_d = VS_STOP;
      default:   st_d = VS_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= VS_STOP;
    else         st_q <= st_d;
  end

  // run follows the controls combinationally so a stop takes effect at once
  assign frozen_o = (st_q == VS_FROZEN);
  assign run_o    = video_en_i && disp_on_i && !frozen_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) df_o <= 1'b0;
    else if (df_mode_i ? evt_i.line_end : evt_i.frame_end) df_o <= ~df_o;
  end
endmodule

// File: rtl/lcd_refresh_ctrl.sv
module lcd_refresh_ctrl
  import lcd_pkg::*;
#(
  parameter int AW  = 20,
  parameter int W_W = 12,
  parameter int H_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  start_addr_i,
  input  logic [AW-1:0]  end_addr_i,
  input  logic [W_W-1:0] width_i,
  input  logic [H_W-1:0] height_i,
  input  logic           color8_i,
  input  logic           split_i,
  input  logic           video_en_i,
  input  logic           disp_on_i,
  input  logic           freeze_i,
  input  logic           invert_i,
  input  logic           df_mode_i,
  input  logic           fetch_gnt_i,
  input  logic [3:0]     pix_data_i,
  output logic [W_W-1:0] hcnt_o,
  output logic [H_W-1:0] lcnt_o,
  output logic           fetch_req_o,
  output logic [AW-1:0]  fetch_addr_o,
  output logic           line_pulse_o,
  output logic           frame_pulse_o,
  output logic           df_o,
  output logic           frame_done_o,
  output logic [3:0]     pix_data_o
);
  logic      run, xfer;
  scan_evt_t evt;

  lcd_geom_decode #(.W_W(W_W), .H_W(H_W)) u_geom (
    .width_i (width_i),
    .height_i(height_i),
    .color8_i(color8_i),
    .split_i (split_i),
    .hcnt_o  (hcnt_o),
    .lcnt_o  (lcnt_o)
  );

  lcd_run_ctrl u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .video_en_i(video_en_i),
    .disp_on_i (disp_on_i),
    .freeze_i  (freeze_i),
    .df_mode_i (df_mode_i),
    .evt_i     (evt),
    .run_o     (run),
    .frozen_o  (frame_done_o),
    .df_o      (df_o)
  );

  assign xfer = run && fetch_gnt_i;

  lcd_scan_ctr #(.W_W(W_W), .H_W(H_W)) u_scan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .xfer_i       (xfer),
    .hcnt_i       (hcnt_o),
    .lcnt_i       (lcnt_o),
    .evt_o        (evt),
    .line_pulse_o (line_pulse_o),
    .frame_pulse_o(frame_pulse_o)
  );

  lcd_fetch_addr #(.AW(AW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .xfer_i      (xfer),
    .frame_end_i (evt.frame_end),
    .start_addr_i(start_addr_i),
    .end_addr_i  (end_addr_i),
    .addr_o      (fetch_addr_o)
  );

  assign fetch_req_o = run;
  assign pix_data_o  = run ? (invert_i ? ~pix_data_i : pix_data_i) : 4'h0;
endmodule

// File: rtl/lcd_refresh_ctrl_chk.sv
module lcd_refresh_ctrl_chk #(
  parameter int AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] start_addr_i,
  input logic [AW-1:0] end_addr_i,
  input logic          df_mode_i,
  input logic          fetch_gnt_i,
  input logic          fetch_req_o,
  input logic [AW-1:0] fetch_addr_o,
  input logic          line_pulse_o,
  input logic          frame_pulse_o,
  input logic          df_o,
  input logic          frame_done_o
);
  AST_FRAME_WITH_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o |-> line_pulse_o); // R5
  AST_LINE_AFTER_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_pulse_o |-> $past(fetch_req_o && fetch_gnt_i)); // R5
  AST_DF_FRAME_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_pulse_o && !$past(df_mode_i)) |-> (df_o != $past(df_o))); // R6
  AST_NO_REQ_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !fetch_req_o); // R7
  AST_FREEZE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_done_o) |-> frame_pulse_o); // R7
  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && $past(fetch_req_o) && $stable(start_addr_i) && $stable(end_addr_i)
     && start_addr_i <= end_addr_i)
    |-> (fetch_addr_o >= start_addr_i && fetch_addr_o <= end_addr_i)); // R4
  AST_RESTART_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fetch_req_o) && $stable(start_addr_i)) |-> (fetch_addr_o == start_addr_i)); // R9
endmodule

bind lcd_refresh_ctrl lcd_refresh_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_addr_i (start_addr_i),
  .end_addr_i   (end_addr_i),
  .df_mode_i    (df_mode_i),
  .fetch_gnt_i  (fetch_gnt_i),
  .fetch_req_o  (fetch_req_o),
  .fetch_addr_o (fetch_addr_o),
  .line_pulse_o (line_pulse_o),
  .frame_pulse_o(frame_pulse_o),
  .df_o         (df_o),
  .frame_done_o (frame_done_o)
);

// File: tb/lcd_refresh_ctrl_tb.sv
module lcd_refresh_ctrl_tb;
  localparam int AW = 20, W_W = 12, H_W = 11;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic [W_W-1:0] width = '0;
  logic [H_W-1:0] height = '0;
  logic color8 = 0, split = 0, video_en = 0, disp_on = 0, freeze = 0;
  logic invert = 0, df_mode = 0, gnt = 0;
  logic [3:0] pix_in = '0;
  logic [W_W-1:0] hcnt;
  logic [H_W-1:0] lcnt;
  logic req, line_p, frame_p, df, done;
  logic [AW-1:0] addr;
  logic [3:0] pix_out;

  int n_chk = 0, n_fail = 0;
  int k = 0;
  bit m_fz = 0, m_df = 0, m_lp = 0, m_fp = 0;

  always #2.5 clk = ~clk;

  lcd_refresh_ctrl #(.AW(AW), .W_W(W_W), .H_W(H_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_addr_i(start_addr), .end_addr_i(end_addr),
    .width_i(width), .height_i(height), .color8_i(color8), .split_i(split),
    .video_en_i(video_en), .disp_on_i(disp_on), .freeze_i(freeze), .invert_i(invert),
    .df_mode_i(df_mode), .fetch_gnt_i(gnt), .pix_data_i(pix_in),
    .hcnt_o(hcnt), .lcnt_o(lcnt), .fetch_req_o(req), .fetch_addr_o(addr),
    .line_pulse_o(line_p), .frame_pulse_o(frame_p), .df_o(df), .frame_done_o(done),
    .pix_data_o(pix_out)
  );

  function automatic int exp_h(int w, bit c8, bit sp);
    return (c8 && !sp) ? (w / 8) * 3 - 1 : w / 4 - 1;
  endfunction
  function automatic int exp_l(int h, bit sp);
    return sp ? h / 2 - 1 : h - 1;
  endfunction

  task automatic chk(bit ok, string req_s, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_s, act, expv);
    end
  endtask

  // check outputs in the low phase, then advance the requirement model one cycle
  task automatic step();
    bit run_m;
    int hp1, tot, span;
    logic [3:0] pe;
    #1;
    run_m = video_en && disp_on && !m_fz;
    hp1 = exp_h(int'(width), color8, split) + 1;
    tot = hp1 * (exp_l(int'(height), split) + 1);
    span = int'(end_addr) - int'(start_addr);
    chk(req == run_m, "R8 fetch_req", req, run_m);
    if (run_m) chk(addr == start_addr + AW'((k < span) ? k : span), "R4/R9 addr", addr,
                   start_addr + AW'((k < span) ? k : span));
    chk(line_p == m_lp, "R5 line_pulse", line_p, m_lp);
    chk(frame_p == m_fp, "R5 frame_pulse", frame_p, m_fp);
    chk(df == m_df, "R6 df", df, m_df);
    chk(done == m_fz, "R7 frame_done", done, m_fz);
    pe = run_m ? (invert ? ~pix_in : pix_in) : 4'h0;
    chk(pix_out == pe, "R10 pix_data", pix_out, pe);
    m_lp = 0; m_fp = 0;
    if (!run_m) k = 0;
    else if (gnt) begin
      k++;
      if (k % hp1 == 0) begin
        m_lp = 1;
        if (df_mode) m_df = ~m_df;
      end
      if (k == tot) begin
        m_fp = 1; k = 0;
        if (!df_mode) m_df = ~m_df;
        if (freeze) m_fz = 1;
      end
    end
    if (!video_en) m_fz = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_cycles(int n, bit full_gnt);
    for (int i = 0; i < n; i++) begin
      gnt = full_gnt ? 1'b1 : ($urandom % 4 != 0);
      pix_in = 4'($urandom);
      step();
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1337));
    start_addr = 20'h00100; end_addr = 20'h00104;
    width = 12'd8; height = 11'd3;
    #12; @(negedge clk);
    // R11 reset state
    chk(req == 0 && line_p == 0 && frame_p == 0 && df == 0 && done == 0, "R11 reset", {req, line_p, frame_p, df, done}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req == 0 && df == 0 && done == 0, "R11 after reset", {req, df, done}, 0);

    // geometry decode: directed then random
    #1;
    chk(hcnt == W_W'(1), "R2 hcnt 4-bit", hcnt, 1);
    chk(lcnt == H_W'(2), "R3 lcnt single", lcnt, 2);
    for (int i = 0; i < 40; i++) begin
      width = W_W'(8 + $urandom % 4000); height = H_W'(2 + $urandom % 1000);
      color8 = $urandom % 2; split = $urandom % 2;
      #1;
      chk(hcnt == W_W'(exp_h(int'(width), color8, split)), (color8 && !split) ? "R1 hcnt" : "R2 hcnt",
          hcnt, exp_h(int'(width), color8, split));
      chk(lcnt == H_W'(exp_l(int'(height), split)), "R3 lcnt", lcnt, exp_l(int'(height), split));
    end
    width = 12'd8; height = 11'd3; color8 = 0; split = 0;
    @(negedge clk);

    // frame A: 2 transfers x 3 lines, end address reached mid-frame
    video_en = 1; disp_on = 1;
    run_cycles(30, 0);
    df_mode = 1;
    run_cycles(20, 0);
    df_mode = 0;
    // R7: freeze takes effect only at frame end
    freeze = 1;
    run_cycles(20, 1);
    chk(done == 1 && req == 0, "R7 frozen after frame", {done, req}, 2'b10);
    // R9: restart requires a cycle with enable low
    video_en = 0; freeze = 0;
    run_cycles(2, 1);
    video_en = 1;
    #1;
    chk(req == 1 && addr == start_addr, "R9 restart at top", addr, start_addr);
    @(negedge clk);
    m_lp = 0; m_fp = 0;
    video_en = 0; run_cycles(1, 1); video_en = 1;
    run_cycles(5, 1);
    // R8: display off mid-frame stops at once
    disp_on = 0;
    run_cycles(3, 1);
    disp_on = 1;
    invert = 1;
    run_cycles(20, 0);
    invert = 0;

    // frame B: 8-bit colour, single panel, 3 transfers x 4 lines (R1)
    video_en = 0;
    run_cycles(1, 1);
    color8 = 1; height = 11'd4; start_addr = 20'h0A000; end_addr = 20'h0A014;
    run_cycles(1, 1);
    video_en = 1;
    run_cycles(40, 0);
    run_cycles(15, 1);

    // frame C: 8-bit colour on a split panel, 2 transfers x 2 lines
    video_en = 0;
    run_cycles(1, 1);
    split = 1; start_addr = 20'h00300; end_addr = 20'h00302;
    run_cycles(1, 1);
    video_en = 1; freeze = 1;
    run_cycles(12, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule